// File: doc/BRIEF.md
# Lower-Half Write Lock for a Serial Configuration Memory

This block sits behind the serial front-end of a 256-byte configuration memory and rules on every byte the front-end is about to store. The front-end presents a write request with the target byte address (or a flag saying the target is the protection register), and one clock later the block returns a verdict. An allowed verdict means the front-end acknowledges the byte and commits it. A refused verdict means the front-end answers NoAck and leaves the location unchanged. Reads never pass through this block and are never restricted by it.

Two controls feed the verdict. The first is a write-control level that refuses every write while it is high. Its unconnected state is taken as low. The second is a one-shot lock flag that covers the lower half of the array, addresses 00h to 7Fh. The front-end sets the flag by pulsing a strobe when a complete protection-register write command has ended with a valid Stop. The address and data bytes of that command carry no meaning. Once the flag is set it never clears. It survives the power-on reset, which models a power cycle. While the flag is set, the block also tells the front-end to stop answering the protection-register type code (0110b) for reads and writes alike.

Top module: `spd_wlock`

## Requirements
- R1: After power-on reset is released, verdict_vld_o and wr_allow_o are 0, and on a never-locked part prot_code_en_o is 1.
- R2: With wc_i low and the lock clear, a request to any array address (wr_prot_i = 0) returns an allowed verdict (verdict_vld_o = 1, wr_allow_o = 1) in the cycle after wr_req_i.
- R3: With wc_i high in the request cycle, every request is refused (verdict_vld_o = 1, wr_allow_o = 0), whether it targets the array or the protection register (wr_prot_i = 1).
- R4: A prot_wr_done_i pulse sampled with wc_i low sets the lock, so prot_code_en_o is 0 from the next cycle on.
- R5: A prot_wr_done_i pulse sampled with wc_i high leaves the lock clear (prot_code_en_o stays 1).
- R6: While locked, requests to addresses 00h–7Fh (address bit 7 = 0) are refused whatever the wc_i level.
- R7: While locked, addresses 80h–FFh follow wc_i alone: allowed when wc_i is low, refused when it is high.
- R8: The lock is never cleared. Neither wc_i nor asserting and releasing rst_ni returns prot_code_en_o to 1 or reopens 00h–7Fh.
- R9: Each wr_req_i cycle yields exactly one verdict pulse in the next cycle, using the wc_i level of that request cycle only. wr_allow_o is 0 whenever verdict_vld_o is 0.
- R10: While locked, a request with wr_prot_i = 1 is refused even with wc_i low.
- R11: Write requests to the protection register that are never followed by a prot_wr_done_i pulse (an aborted command) leave the lock clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset; does not clear the lock |
| wr_req_i | input | 1 | One-cycle request to rule on a data byte write |
| wr_prot_i | input | 1 | Request targets the protection register instead of the array |
| wr_addr_i | input | 8 | Target byte address in the array |
| wc_i | input | 1 | Write-control level; high refuses all writes |
| prot_wr_done_i | input | 1 | Pulse: protection-register write ended with a valid Stop |
| verdict_vld_o | output | 1 | Verdict pulse, one cycle after wr_req_i |
| wr_allow_o | output | 1 | Verdict: 1 means acknowledge and commit, 0 means NoAck |
| prot_code_en_o | output | 1 | Front-end may still answer type code 0110b |

## Verification
The ruling is tried on a fresh part with wc_i low and with wc_i high across low, high and boundary addresses (00h, 7Fh, 80h, FFh). These cases separate the write-control path from the address path. Aborted protection-register commands and completion strobes raised under wc_i high are driven before the real lock, which shows that only a completed, write-enabled strobe arms the flag. After locking, the same address sweep under both wc_i levels shows the lower half closed while the upper half still tracks wc_i. A reset pulse then shows the lock outliving the power cycle. Back-to-back requests with wc_i toggling between them show that each verdict depends only on its own byte.

// File: rtl/spd_wlock_pkg.sv
package spd_wlock_pkg;

  typedef struct packed {
    logic vld;
    logic allow;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{vld: 1'b0, allow: 1'b0};

endpackage

// File: rtl/spd_wlock_cell.sv
// One-shot lock flag. No reset: its state outlives the power-on reset.
module spd_wlock_cell #(
  parameter bit LOCK_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic set_i,
  output logic locked_o
);

  logic lock_q = LOCK_INIT;

  always_ff @(posedge clk_i) begin
    if (set_i) lock_q <= 1'b1;
  end

  assign locked_o = lock_q;

endmodule

// File: rtl/spd_wlock_rule.sv
// Combinational ruling for one byte write attempt.
module spd_wlock_rule #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wc_i,
  input  logic              locked_i,
  output logic              allow_o
);

  localparam int unsigned LOCK_BIT = ADDR_W - 1;

  logic in_locked_half;

  assign in_locked_half = ~addr_i[LOCK_BIT];

  always_comb begin
    if (wc_i)        allow_o = 1'b0;
    else if (prot_i) allow_o = ~locked_i;
    else             allow_o = ~(locked_i & in_locked_half);
  end

endmodule

// File: rtl/spd_wlock_verdict.sv
module spd_wlock_verdict
  import spd_wlock_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     allow_i,
  output verdict_t verdict_o
);

  verdict_t verdict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    verdict_q <= VERDICT_IDLE;
    else if (req_i) verdict_q <= '{vld: 1'b1, allow: allow_i};
    else            verdict_q <= VERDICT_IDLE;
  end

  assign verdict_o = verdict_q;

endmodule

// File: rtl/spd_wlock.sv
module spd_wlock
  import spd_wlock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter bit          LOCK_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic              wr_prot_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wc_i,
  input  logic              prot_wr_done_i,
  output logic              verdict_vld_o,
  output logic              wr_allow_o,
  output logic              prot_code_en_o
);

  logic     locked;
  logic     allow_now;
  logic     lock_set;
  verdict_t verdict;

  // Strobe counts only while the part is out of reset and writes are enabled.
  assign lock_set = prot_wr_done_i & ~wc_i & rst_ni;

  spd_wlock_cell #(.LOCK_INIT(LOCK_INIT)) u_cell (
    .clk_i    (clk_i),
    .set_i    (lock_set),
    .locked_o (locked)
  );

  spd_wlock_rule #(.ADDR_W(ADDR_W)) u_rule (
    .prot_i   (wr_prot_i),
    .addr_i   (wr_addr_i),
    .wc_i     (wc_i),
    .locked_i (locked),
    .allow_o  (allow_now)
  );

  spd_wlock_verdict u_verdict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (wr_req_i),
    .allow_i   (allow_now),
    .verdict_o (verdict)
  );

  assign verdict_vld_o  = verdict.vld;
  assign wr_allow_o     = verdict.allow;
  assign prot_code_en_o = ~locked;

endmodule

// File: rtl/spd_wlock_chk.sv
module spd_wlock_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_req_i,
  input logic              wr_prot_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wc_i,
  input logic              prot_wr_done_i,
  input logic              verdict_vld_o,
  input logic              wr_allow_o,
  input logic              prot_code_en_o
);

  assert_wc_refuses_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && wc_i |=> verdict_vld_o && !wr_allow_o);

  assert_lock_arms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_wr_done_i && !wc_i |=> !prot_code_en_o);

  assert_lower_half_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !wr_prot_i && !wr_addr_i[ADDR_W-1] && !prot_code_en_o |=> !wr_allow_o);

  assert_upper_half_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !wr_prot_i && wr_addr_i[ADDR_W-1] && !wc_i |=> wr_allow_o);

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_code_en_o |=> !prot_code_en_o);

  assert_one_verdict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> verdict_vld_o);

  assert_no_spurious_verdict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> !verdict_vld_o);

  assert_allow_needs_vld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_vld_o |-> !wr_allow_o);

  assert_prot_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && wr_prot_i && !prot_code_en_o |=> !wr_allow_o);

endmodule

bind spd_wlock spd_wlock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_req_i       (wr_req_i),
  .wr_prot_i      (wr_prot_i),
  .wr_addr_i      (wr_addr_i),
  .wc_i           (wc_i),
  .prot_wr_done_i (prot_wr_done_i),
  .verdict_vld_o  (verdict_vld_o),
  .wr_allow_o     (wr_allow_o),
  .prot_code_en_o (prot_code_en_o)
);

// File: tb/spd_wlock_test.sv
`timescale 1ns/1ps
module spd_wlock_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_req_i = 1'b0;
  logic       wr_prot_i = 1'b0;
  logic [7:0] wr_addr_i = 8'h00;
  logic       wc_i = 1'b0;
  logic       prot_wr_done_i = 1'b0;
  logic       verdict_vld_o;
  logic       wr_allow_o;
  logic       prot_code_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  spd_wlock uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_req_i       (wr_req_i),
    .wr_prot_i      (wr_prot_i),
    .wr_addr_i      (wr_addr_i),
    .wc_i           (wc_i),
    .prot_wr_done_i (prot_wr_done_i),
    .verdict_vld_o  (verdict_vld_o),
    .wr_allow_o     (wr_allow_o),
    .prot_code_en_o (prot_code_en_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Request in one cycle, sample the verdict at the following negedge.
  task automatic write_byte(input logic [7:0] a, input logic prot, input logic wc,
                            input logic exp_allow, input string req);
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_prot_i = prot; wr_addr_i = a; wc_i = wc;
    @(negedge clk_i);
    wr_req_i = 1'b0; wr_prot_i = 1'b0; wc_i = 1'b0;
    check(req, $sformatf("vld addr %02h", a), verdict_vld_o, 1'b1);
    check(req, $sformatf("allow addr %02h wc %b prot %b", a, wc, prot), wr_allow_o, exp_allow);
  endtask

  task automatic pulse_done(input logic wc);
    @(negedge clk_i);
    prot_wr_done_i = 1'b1; wc_i = wc;
    @(negedge clk_i);
    prot_wr_done_i = 1'b0; wc_i = 1'b0;
  endtask

  task automatic t_reset_state;
    check("R1", "vld after reset", verdict_vld_o, 1'b0);
    check("R1", "allow after reset", wr_allow_o, 1'b0);
    check("R1", "code enable fresh", prot_code_en_o, 1'b1);
  endtask

  task automatic t_open_part;
    write_byte(8'h00, 1'b0, 1'b0, 1'b1, "R2");
    write_byte(8'h7F, 1'b0, 1'b0, 1'b1, "R2");
    write_byte(8'h80, 1'b0, 1'b0, 1'b1, "R2");
    write_byte(8'hFF, 1'b0, 1'b0, 1'b1, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_wc_high;
    write_byte(8'h10, 1'b0, 1'b1, 1'b0, "R3");
    write_byte(8'hC3, 1'b0, 1'b1, 1'b0, "R3");
    write_byte(8'h55, 1'b1, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_aborted_cmd;
    write_byte(8'h00, 1'b1, 1'b0, 1'b1, "R11");
    write_byte(8'h00, 1'b1, 1'b0, 1'b1, "R11");
    repeat (3) @(negedge clk_i);
    check("R11", "code enable after abort", prot_code_en_o, 1'b1);
    write_byte(8'h22, 1'b0, 1'b0, 1'b1, "R11");
  endtask

  task automatic t_done_under_wc;
    pulse_done(1'b1);
    check("R5", "code enable after wc-high strobe", prot_code_en_o, 1'b1);
    write_byte(8'h05, 1'b0, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_arm_lock;
    pulse_done(1'b0);
    check("R4", "code enable after strobe", prot_code_en_o, 1'b0);
  endtask

  task automatic t_locked_map;
    write_byte(8'h00, 1'b0, 1'b0, 1'b0, "R6");
    write_byte(8'h7F, 1'b0, 1'b0, 1'b0, "R6");
    write_byte(8'h40, 1'b0, 1'b1, 1'b0, "R6");
    write_byte(8'h80, 1'b0, 1'b0, 1'b1, "R7");
    write_byte(8'hFF, 1'b0, 1'b0, 1'b1, "R7");
    write_byte(8'hA0, 1'b0, 1'b1, 1'b0, "R7");
    write_byte(8'h00, 1'b1, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_back_to_back;
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_addr_i = 8'h90; wc_i = 1'b0;
    @(negedge clk_i);
    check("R9", "first vld", verdict_vld_o, 1'b1);
    check("R9", "first allow", wr_allow_o, 1'b1);
    wr_addr_i = 8'h91; wc_i = 1'b1;
    @(negedge clk_i);
    check("R9", "second vld", verdict_vld_o, 1'b1);
    check("R9", "second allow", wr_allow_o, 1'b0);
    wr_addr_i = 8'h92; wc_i = 1'b0;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    check("R9", "third allow", wr_allow_o, 1'b1);
    @(negedge clk_i);
    check("R9", "idle vld", verdict_vld_o, 1'b0);
    check("R9", "idle allow", wr_allow_o, 1'b0);
  endtask

  task automatic t_power_cycle;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8", "code enable after reset", prot_code_en_o, 1'b0);
    check("R8", "vld after reset", verdict_vld_o, 1'b0);
    write_byte(8'h12, 1'b0, 1'b0, 1'b0, "R8");
    pulse_done(1'b1);
    check("R8", "code enable after wc toggle", prot_code_en_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_open_part();
    t_wc_high();
    t_aborted_cmd();
    t_done_under_wc();
    t_arm_lock();
    t_locked_map();
    t_back_to_back();
    t_power_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule